// File: doc/BRIEF.md
# Decimating Related-Clock Sample Transfer

This block moves a continuous stream of samples from a fast clock domain into a slow one. The slow clock is the fast clock divided by a fixed ratio (16 by default). Both clocks come from one source and have zero phase offset. On the fast side, every incoming sample is written into a circular slot buffer with one slot per ratio step. A modulo counter and a comparator mark the last slot of each group with a one-cycle strobe. The slow side reads only that last slot, once per slow cycle, so it keeps one sample in every group and drops the rest.

There is no flow control and no handshake; the buffer is simply overwritten on every pass. Start-up is aligned by an event. The first group strobe after reset sets a sticky flag in the fast domain. A synchronizer chain carries that flag into the slow domain, and the slow-side output becomes valid only after the flag arrives. The decimation ratio, the sample width and the synchronizer depth are parameters that are checked at elaboration.

Top module: `decim_xfer`

## Requirements
- R1: Count fast edges after reset release from k=0. `grp_strobe` is high after fast edge k exactly when k mod RATIO equals RATIO-2, which is the cycle in which slot RATIO-1 is written. It is therefore high for one fast cycle in every RATIO.
- R2: The sample present at fast edge k is written to slot k mod RATIO, so slots fill in ascending order and wrap after RATIO-1.
- R3: Count slow edges after reset release from j=1, where the first slow edge coincides with fast edge k=0. Once valid, after slow edge j the output equals the sample captured at fast edge RATIO*(j-1)-1. This is the last sample of the group just completed; the other RATIO-1 samples of each group never reach the output.
- R4: `out_valid` is low and `out_sample` is zero until start-up completes. With the default two-stage synchronizer, `out_valid` first goes high at slow edge j=4.
- R5: Once high, `out_valid` stays high until reset, and a new sample is presented on every slow edge.
- R6: Asserting the active-low resets clears `out_valid`, `out_sample` and `grp_strobe` at once, without a clock edge.
- R7: After a reset in mid-stream and a new release, the start-up latency and the output mapping of R3 and R4 hold again.
- R8: A RATIO that is not a power of two of at least 2, or a synchronizer depth below 2, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast sample clock |
| fast_rst_n | input | 1 | Active-low asynchronous reset, fast domain |
| in_sample | input | DATA_W | Incoming sample, taken on every fast edge |
| grp_strobe | output | 1 | One-cycle marker of the slot RATIO-1 write |
| slow_clk | input | 1 | Slow clock, fast clock divided by RATIO, in phase |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| out_sample | output | DATA_W | Decimated sample |
| out_valid | output | 1 | High once start-up has completed |

## Verification
The bench feeds a stream in which every sample is distinct, so an output taken from the wrong slot, or taken one group early or late, shows up as a specific wrong value. It checks the exact slow edge at which the output first becomes valid. A design that passes a single-cycle pulse straight to the slow side would never start, and one with a missing synchronizer stage would start one slow cycle early. It also resets the block mid-stream and checks that the outputs clear at once without a clock edge, then restarts with a second data pattern. A design with leftover start state would become valid too soon after that restart. The group strobe is checked on every fast cycle, which exposes an off-by-one comparator.

// File: rtl/decim_xfer_pkg.sv
package decim_xfer_pkg;

   // true when v is a power of two and at least 2
   function automatic bit ratio_ok(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/decim_phase_gen.sv
module decim_phase_gen #(
   parameter int RATIO  = 16,
   parameter int ADDR_W = $clog2(RATIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] slot,
   output logic              last_slot
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(RATIO - 1);

   logic [ADDR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign slot      = cnt_q;
   assign last_slot = (cnt_q == LAST);
endmodule

// File: rtl/decim_slot_mem.sv
module decim_slot_mem #(
   parameter int DATA_W = 16,
   parameter int RATIO  = 16,
   parameter int ADDR_W = $clog2(RATIO)
) (
   input  logic              wr_clk,
   input  logic [ADDR_W-1:0] wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   localparam int RD_SLOT = RATIO - 1;

   logic [DATA_W-1:0] slots [RATIO];
   logic [DATA_W-1:0] rd_q;

   always_ff @(posedge wr_clk) begin
      slots[wr_slot] <= wr_data;
   end

   // fixed-address read port in the slow domain
   always_ff @(posedge rd_clk or negedge rd_rst_n) begin
      if (!rd_rst_n)  rd_q <= '0;
      else if (rd_en) rd_q <= slots[RD_SLOT];
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/decim_start_sync.sv
module decim_start_sync #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic src_rst_n,
   input  logic src_event,
   output logic src_flag,
   input  logic dst_clk,
   input  logic dst_rst_n,
   output logic dst_flag
);
   logic             flag_q;
   logic [STAGES-1:0] chain_q;

   // sticky level so the slower clock cannot miss a one-cycle event
   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n)     flag_q <= 1'b0;
      else if (src_event) flag_q <= 1'b1;
   end

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) chain_q[0] <= 1'b0;
      else            chain_q[0] <= flag_q;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge dst_clk or negedge dst_rst_n) begin
         if (!dst_rst_n) chain_q[s] <= 1'b0;
         else            chain_q[s] <= chain_q[s-1];
      end
   end

   assign src_flag = flag_q;
   assign dst_flag = chain_q[STAGES-1];
endmodule

// File: rtl/decim_xfer.sv
module decim_xfer
   import decim_xfer_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int RATIO       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              fast_clk,
   input  logic              fast_rst_n,
   input  logic [DATA_W-1:0] in_sample,
   output logic              grp_strobe,
   input  logic              slow_clk,
   input  logic              slow_rst_n,
   output logic [DATA_W-1:0] out_sample,
   output logic              out_valid
);
   localparam int ADDR_W = $clog2(RATIO);

   // R8 elaboration-time parameter checks
   if (!ratio_ok(RATIO)) begin : g_bad_ratio
      $error("decim_xfer: RATIO must be a power of two of at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("decim_xfer: SYNC_STAGES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("decim_xfer: DATA_W must be positive");
   end

   logic [ADDR_W-1:0] wr_slot;
   logic              last_slot;
   logic              start_flag_fast;
   logic              started_slow;
   logic              valid_q;

   decim_phase_gen #(.RATIO(RATIO), .ADDR_W(ADDR_W)) u_phase (
      .clk       (fast_clk),
      .rst_n     (fast_rst_n),
      .slot      (wr_slot),
      .last_slot (last_slot)
   );

   decim_slot_mem #(.DATA_W(DATA_W), .RATIO(RATIO), .ADDR_W(ADDR_W)) u_mem (
      .wr_clk   (fast_clk),
      .wr_slot  (wr_slot),
      .wr_data  (in_sample),
      .rd_clk   (slow_clk),
      .rd_rst_n (slow_rst_n),
      .rd_en    (started_slow),
      .rd_data  (out_sample)
   );

   decim_start_sync #(.STAGES(SYNC_STAGES)) u_start (
      .src_clk   (fast_clk),
      .src_rst_n (fast_rst_n),
      .src_event (last_slot),
      .src_flag  (start_flag_fast),
      .dst_clk   (slow_clk),
      .dst_rst_n (slow_rst_n),
      .dst_flag  (started_slow)
   );

   always_ff @(posedge slow_clk or negedge slow_rst_n) begin
      if (!slow_rst_n) valid_q <= 1'b0;
      else             valid_q <= started_slow;
   end

   assign grp_strobe = last_slot;
   assign out_valid  = valid_q;
endmodule

// File: rtl/decim_xfer_chk.sv
module decim_xfer_chk #(
   parameter int DATA_W = 16,
   parameter int RATIO  = 16
) (
   input logic              fast_clk,
   input logic              fast_rst_n,
   input logic              slow_clk,
   input logic              slow_rst_n,
   input logic              grp_strobe,
   input logic              start_flag_fast,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_sample
);
   localparam int GAP_W = $clog2(RATIO) + 1;

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge fast_clk or negedge fast_rst_n) begin
      if (!fast_rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (grp_strobe) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R1
   strobe_single_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
      grp_strobe |=> !grp_strobe);

   // R1
   strobe_period_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
      (grp_strobe && seen_q) |-> (gap_q == GAP_W'(RATIO - 1)));

   // R4
   start_sticky_chk: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
      start_flag_fast |=> start_flag_fast);

   // R4
   idle_zero_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      !out_valid |-> (out_sample == '0));

   // R4
   start_order_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      $rose(out_valid) |-> start_flag_fast);

   // R5
   valid_sticky_chk: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
      out_valid |=> out_valid);
endmodule

bind decim_xfer decim_xfer_chk #(.DATA_W(DATA_W), .RATIO(RATIO)) u_chk (
   .fast_clk        (fast_clk),
   .fast_rst_n      (fast_rst_n),
   .slow_clk        (slow_clk),
   .slow_rst_n      (slow_rst_n),
   .grp_strobe      (grp_strobe),
   .start_flag_fast (start_flag_fast),
   .out_valid       (out_valid),
   .out_sample      (out_sample)
);

// File: tb/tb_decim_xfer.sv
`timescale 1ns/1ps
module tb_decim_xfer;
   localparam int DATA_W   = 16;
   localparam int RATIO    = 16;
   localparam int FIRST_OK = 4;   // first valid slow edge with two sync stages

   logic              fast_clk   = 1'b0;
   logic              slow_clk   = 1'b0;
   logic              fast_rst_n = 1'b0;
   logic              slow_rst_n = 1'b0;
   logic [DATA_W-1:0] in_sample  = '0;
   logic              grp_strobe;
   logic [DATA_W-1:0] out_sample;
   logic              out_valid;

   int errors = 0;
   int checks = 0;
   int k      = 0;   // fast edges since release
   int j      = 0;   // slow edges since release
   int pat_sel = 0;
   bit done   = 1'b0;

   decim_xfer #(.DATA_W(DATA_W), .RATIO(RATIO), .SYNC_STAGES(2)) dut (
      .fast_clk   (fast_clk),
      .fast_rst_n (fast_rst_n),
      .in_sample  (in_sample),
      .grp_strobe (grp_strobe),
      .slow_clk   (slow_clk),
      .slow_rst_n (slow_rst_n),
      .out_sample (out_sample),
      .out_valid  (out_valid)
   );

   // 100 MHz fast clock, rising at 5 + 10n
   initial forever #5 fast_clk = ~fast_clk;

   // divided clock, rising edges coincide with every 16th fast edge
   initial begin
      #5;
      forever begin
         slow_clk = 1'b1; #80;
         slow_clk = 1'b0; #80;
      end
   end

   function automatic logic [DATA_W-1:0] pat(input int sel, input int idx);
      if (sel == 0) return DATA_W'(idx * 37 + 5);
      else          return DATA_W'(~(idx * 3)) ^ DATA_W'(16'h5A5A);
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge fast_clk or negedge fast_rst_n) begin
      if (!fast_rst_n) k <= 0;
      else             k <= k + 1;
   end

   always @(posedge slow_clk or negedge slow_rst_n) begin
      if (!slow_rst_n) j <= 0;
      else             j <= j + 1;
   end

   // drive samples and check the strobe away from the rising edge
   always @(negedge fast_clk) begin
      in_sample = pat(pat_sel, k);
      if (fast_rst_n && k > 0 && !done) begin
         // R1
         check(grp_strobe == (((k - 1) % RATIO) == RATIO - 2), "R1 strobe",
               grp_strobe, (((k - 1) % RATIO) == RATIO - 2));
      end
   end

   always @(negedge slow_clk) begin
      if (slow_rst_n && !done) begin
         if (j < FIRST_OK) begin
            // R4 R7
            check(out_valid == 1'b0, "R4 R7 valid before start", out_valid, 0);
            check(out_sample == '0, "R4 zero before start", out_sample, 0);
         end else begin
            // R5
            check(out_valid == 1'b1, "R5 R7 valid", out_valid, 1);
            // R2 R3
            check(out_sample == pat(pat_sel, RATIO * (j - 1) - 1), "R2 R3 sample",
                  out_sample, pat(pat_sel, RATIO * (j - 1) - 1));
         end
      end
   end

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // reset state
      #2;
      check(out_valid == 1'b0, "R6 reset valid", out_valid, 0);
      check(out_sample == '0, "R6 reset sample", out_sample, 0);
      check(grp_strobe == 1'b0, "R6 reset strobe", grp_strobe, 0);

      @(posedge slow_clk);
      @(posedge slow_clk);
      #157;
      fast_rst_n = 1'b1;
      slow_rst_n = 1'b1;

      repeat (12) @(posedge slow_clk);
      #83;
      fast_rst_n = 1'b0;
      slow_rst_n = 1'b0;
      #1;
      // R6
      check(out_valid == 1'b0, "R6 async valid", out_valid, 0);
      check(out_sample == '0, "R6 async sample", out_sample, 0);
      check(grp_strobe == 1'b0, "R6 async strobe", grp_strobe, 0);

      pat_sel = 1;
      @(posedge slow_clk);
      #157;
      fast_rst_n = 1'b1;   // R7 restart with a second pattern
      slow_rst_n = 1'b1;

      repeat (10) @(posedge slow_clk);
      #90;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule